// File: doc/BRIEF.md
# Loadable Up/Down Position Counter

This block keeps the position word of a tracking converter. An upstream tracking loop reports each one-LSB movement of the shaft as a single-cycle step strobe, either upward or downward. The counter applies the step and wraps at the ends of its range. It also drives a direction flag and emits a one-cycle busy pulse for every step it takes.

Firmware can write the count through a parallel port. A plain write replaces the count with the data word. A write with the clear qualifier set works as a mask: it clears each counter bit whose data bit is 1 and keeps the other bits. For example, a count of 10101 with data 11000 becomes 00101.

The tracking loop can also report a reversal of rotation that is smaller than one LSB, through a separate direction hint. The direction flag can therefore change several times between two count updates. A direction change caused by a step is registered in the same cycle as the count and busy updates for that step.

Top module: `pos_track_counter`

## Requirements
- R1: During and after reset the count is 0, `dir_up` is 1 and `busy` is 0.
- R2: A cycle with `step_up`=1, `step_dn`=0 and `load_en`=0 adds one to the count on the next clock edge. In the same update `busy` is 1 and `dir_up` is 1.
- R3: A cycle with `step_dn`=1, `step_up`=0 and `load_en`=0 subtracts one from the count on the next clock edge. In the same update `busy` is 1 and `dir_up` is 0.
- R4: The count wraps modulo 2^WIDTH in both directions. The all-ones value stepped up becomes 0, and 0 stepped down becomes all-ones. A wrapping step raises `busy` like any other step.
- R5: When `step_up` and `step_dn` are both 1 without a load, the two requests cancel. The count, `dir_up` and `busy`=0 behave as in an idle cycle.
- R6: When `load_en`=1 and `load_clr`=0, the count becomes `load_data` on the next edge and `busy` stays 0.
- R7: When `load_en`=1 and `load_clr`=1, each count bit whose `load_data` bit is 1 is cleared. Each count bit whose data bit is 0 keeps its value. `busy` stays 0.
- R8: A load takes priority over a step request in the same cycle. The step is discarded, so the count takes the load result, `busy` stays 0 and `dir_up` does not follow the step.
- R9: `load_clr` has no effect on the count when `load_en` is 0.
- R10: When `dir_hint_vld`=1 and no step is applied, `dir_up` takes the value of `dir_hint_up` on the next edge, and the count and `busy` do not change. If a step is applied in the same cycle, the sense of the step wins.
- R11: `busy` is a registered pulse. It is 1 for exactly the cycles that follow an applied step, and 0 after any cycle with no applied step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_up | input | 1 | One-LSB increment request |
| step_dn | input | 1 | One-LSB decrement request |
| load_en | input | 1 | Parallel write strobe |
| load_clr | input | 1 | Turns a write into a masked clear |
| load_data | input | WIDTH | Write data or clear mask |
| dir_hint_vld | input | 1 | Reversal report that is smaller than one LSB |
| dir_hint_up | input | 1 | Reported direction, 1 meaning upward |
| count | output | WIDTH | Position word |
| dir_up | output | 1 | Direction of rotation, 1 meaning upward |
| busy | output | 1 | One-cycle pulse after each applied step |

## Verification
A firmware write and a tracking step can land in the same cycle. A direction hint and a step can also coincide. Both collisions are provoked on purpose: up and down step strobes are raised together with plain and masked writes, and a direction hint is raised together with an opposite step. The results are judged at the ports. After a collision with a write, the count must equal the write result, `busy` must stay low and `dir_up` must keep its old value. After a collision with a hint, the step's direction must win and the count must move by one.

// File: rtl/pos_track_pkg.sv
package pos_track_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_PLAIN = 2'd1,
        WR_MASK  = 2'd2
    } write_e;

endpackage

// File: rtl/ptc_req_arb.sv
module ptc_req_arb
    import pos_track_pkg::*;
(
    input  logic   up_i,
    input  logic   dn_i,
    input  logic   wr_i,
    input  logic   clr_i,
    output step_e  step_o,
    output write_e wr_o
);
    always_comb begin
        wr_o   = WR_NONE;
        step_o = STEP_NONE;
        if (wr_i) begin
            // a write discards any step request of the same cycle
            wr_o = clr_i ? WR_MASK : WR_PLAIN;
        end else if (up_i && !dn_i) begin
            step_o = STEP_INC;
        end else if (dn_i && !up_i) begin
            step_o = STEP_DEC;
        end
    end
endmodule

// File: rtl/ptc_write_merge.sv
module ptc_write_merge
    import pos_track_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  write_e           mode_i,
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] res_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            unique case (mode_i)
                WR_PLAIN: res_o[b] = data_i[b];
                WR_MASK:  res_o[b] = cur_i[b] & ~data_i[b];
                default:  res_o[b] = cur_i[b];
            endcase
        end
    end
endmodule

// File: rtl/ptc_dir_sel.sv
module ptc_dir_sel
    import pos_track_pkg::*;
(
    input  step_e step_i,
    input  logic  hint_vld_i,
    input  logic  hint_up_i,
    input  logic  cur_i,
    output logic  dir_o
);
    always_comb begin
        unique case (step_i)
            STEP_INC: dir_o = 1'b1;
            STEP_DEC: dir_o = 1'b0;
            default:  dir_o = hint_vld_i ? hint_up_i : cur_i;
        endcase
    end
endmodule

// File: rtl/pos_track_counter.sv
module pos_track_counter
    import pos_track_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             load_en,
    input  logic             load_clr,
    input  logic [WIDTH-1:0] load_data,
    input  logic             dir_hint_vld,
    input  logic             dir_hint_up,
    output logic [WIDTH-1:0] count,
    output logic             dir_up,
    output logic             busy
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             dir;
        logic             bsy;
    } state_t;

    state_t st_d, st_q;

    step_e            step_sel;
    write_e           wr_sel;
    logic [WIDTH-1:0] wr_res;
    logic             dir_nxt;

    ptc_req_arb u_arb (
        .up_i   (step_up),
        .dn_i   (step_dn),
        .wr_i   (load_en),
        .clr_i  (load_clr),
        .step_o (step_sel),
        .wr_o   (wr_sel)
    );

    ptc_write_merge #(.WIDTH(WIDTH)) u_merge (
        .mode_i (wr_sel),
        .cur_i  (st_q.cnt),
        .data_i (load_data),
        .res_o  (wr_res)
    );

    ptc_dir_sel u_dir (
        .step_i     (step_sel),
        .hint_vld_i (dir_hint_vld),
        .hint_up_i  (dir_hint_up),
        .cur_i      (st_q.dir),
        .dir_o      (dir_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.dir = dir_nxt;
        st_d.bsy = 1'b0;
        unique case (step_sel)
            STEP_INC: begin
                st_d.cnt = st_q.cnt + ONE;
                st_d.bsy = 1'b1;
            end
            STEP_DEC: begin
                st_d.cnt = st_q.cnt - ONE;
                st_d.bsy = 1'b1;
            end
            default: st_d.cnt = wr_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, dir: 1'b1, bsy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.cnt;
    assign dir_up = st_q.dir;
    assign busy   = st_q.bsy;

    // R2 R3: every busy pulse goes with a one-LSB move in the flagged sense
    p_busy_step_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((dir_up && count == $past(count) + ONE) ||
                  (!dir_up && count == $past(count) - ONE)));

    p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
        (step_up && step_dn && !load_en) |=> (!busy && $stable(count) && $stable(dir_up)) || $past(dir_hint_vld));

    p_load_plain_r6: assert property (@(posedge clk) disable iff (rst)
        (load_en && !load_clr) |=> count == $past(load_data));

    p_load_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_clr) |=> count == ($past(count) & ~$past(load_data)));

    p_load_prio_r8: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !busy);

    p_hint_r10: assert property (@(posedge clk) disable iff (rst)
        (dir_hint_vld && !load_en && step_up == step_dn) |=> dir_up == $past(dir_hint_up));

    // R9 R11: a cycle with no request leaves count alone and drops busy
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!step_up && !step_dn && !load_en) |=> (!busy && $stable(count)));

endmodule

// File: tb/sim_pos_track_counter.sv
module sim_pos_track_counter;
    localparam int W      = 12;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         step_up, step_dn, load_en, load_clr, dir_hint_vld, dir_hint_up;
    logic [W-1:0] load_data;
    logic [W-1:0] count;
    logic         dir_up, busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    pos_track_counter #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .step_up(step_up), .step_dn(step_dn),
        .load_en(load_en), .load_clr(load_clr), .load_data(load_data),
        .dir_hint_vld(dir_hint_vld), .dir_hint_up(dir_hint_up),
        .count(count), .dir_up(dir_up), .busy(busy)
    );

    typedef struct packed {
        logic       up, dn, ld, cl, hv, hu;
        logic [W-1:0] data;
        logic [W-1:0] cnt;
        logic       dir, bsy;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    // fields: up dn ld cl hv hu data | expected count dir busy | requirement
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,0,0,12'h000, 12'h001,1,1, 2},  // R2 step up
        '{0,0,0,0,0,0,12'h000, 12'h001,1,0, 11}, // R11 busy drops
        '{0,1,0,0,0,0,12'h000, 12'h000,0,1, 3},  // R3 step down
        '{0,1,0,0,0,0,12'h000, 12'hFFF,0,1, 4},  // R4 wrap down
        '{1,0,0,0,0,0,12'h000, 12'h000,1,1, 4},  // R4 wrap up
        '{0,0,1,0,0,0,12'h555, 12'h555,1,0, 6},  // R6 plain write
        '{0,0,1,1,0,0,12'h0F0, 12'h505,1,0, 7},  // R7 masked clear
        '{1,1,0,0,0,0,12'h000, 12'h505,1,0, 5},  // R5 cancel
        '{1,0,1,0,0,0,12'h7FF, 12'h7FF,1,0, 8},  // R8 write beats up
        '{0,1,1,0,0,0,12'h100, 12'h100,1,0, 8},  // R8 write beats down, dir kept
        '{0,0,0,1,0,0,12'hFFF, 12'h100,1,0, 9},  // R9 clear without write
        '{0,0,0,0,1,0,12'h000, 12'h100,0,0, 10}, // R10 hint down
        '{0,0,0,0,1,1,12'h000, 12'h100,1,0, 10}, // R10 hint up
        '{0,1,0,0,1,1,12'h000, 12'h0FF,0,1, 10}, // R10 step sense wins
        '{0,0,1,0,0,0,12'hFFF, 12'hFFF,0,0, 6},  // R6
        '{1,0,0,0,0,0,12'h000, 12'h000,1,1, 4},  // R4 wrap up from write
        '{0,0,1,0,0,0,12'h015, 12'h015,1,0, 6},  // R6 10101
        '{0,0,1,1,0,0,12'h018, 12'h005,1,0, 7}   // R7 mask 11000 -> 00101
    };

    task automatic drive(input logic u, d, l, c, hv, hu, input logic [W-1:0] dat);
        step_up = u; step_dn = d; load_en = l; load_clr = c;
        dir_hint_vld = hv; dir_hint_up = hu; load_data = dat;
    endtask

    task automatic check(input int req, input logic [W-1:0] ec, input logic ed, input logic eb);
        n_chk++;
        if (count !== ec || dir_up !== ed || busy !== eb) begin
            n_fail++;
            $display("FAIL R%0d: count=%h dir=%b busy=%b expected count=%h dir=%b busy=%b",
                     req, count, dir_up, busy, ec, ed, eb);
        end
    endtask

    task automatic step_cycle(input logic u, d, l, c, hv, hu, input logic [W-1:0] dat);
        @(negedge clk);
        drive(u, d, l, c, hv, hu, dat);
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, '0);
        repeat (3) @(posedge clk);
        #1;
        check(1, '0, 1'b1, 1'b0);  // R1 during reset
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(1, '0, 1'b1, 1'b0);  // R1 after release

        for (int i = 0; i < NV; i++) begin
            step_cycle(VEC[i].up, VEC[i].dn, VEC[i].ld, VEC[i].cl, VEC[i].hv, VEC[i].hu, VEC[i].data);
            check(int'(VEC[i].req), VEC[i].cnt, VEC[i].dir, VEC[i].bsy);
        end

        // R11: held up request pulses busy each cycle, three steps
        for (int k = 1; k <= 3; k++) begin
            step_cycle(1, 0, 0, 0, 0, 0, '0);
            check(11, W'(12'h005 + k), 1'b1, 1'b1);
        end
        step_cycle(0, 0, 0, 0, 0, 0, '0);
        check(11, 12'h008, 1'b1, 1'b0);

        // R5: cancel with a pending down direction keeps dir low
        step_cycle(0, 1, 0, 0, 0, 0, '0);
        check(3, 12'h007, 1'b0, 1'b1);
        step_cycle(1, 1, 0, 0, 0, 0, '0);
        check(5, 12'h007, 1'b0, 1'b0);

        // R7: mask of all ones clears everything, mask of zero keeps all
        step_cycle(0, 0, 1, 0, 0, 0, 12'hA5A);
        check(6, 12'hA5A, 1'b0, 1'b0);
        step_cycle(0, 0, 1, 1, 0, 0, 12'h000);
        check(7, 12'hA5A, 1'b0, 1'b0);
        step_cycle(0, 0, 1, 1, 0, 0, 12'hFFF);
        check(7, 12'h000, 1'b0, 1'b0);

        // R1: reset in mid-run
        step_cycle(1, 0, 0, 0, 0, 0, '0);
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, '0);
        @(posedge clk);
        #1;
        check(1, '0, 1'b1, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule